// File: doc/BRIEF.md
# Lock-Step Shared Register Memory with Same-Cycle Conflict Policies

This block is a small register-array memory shared by several processor ports that all advance together, one access step per clock. In every step each port may present one read and one write. All reads of a step observe the memory as it stood before that step, and all writes of the step then land together. The read data and the per-port error flags appear one clock after the request.

When several ports touch one location in the same step, a run-time mode decides the outcome. A two-bit exclusivity field can forbid shared reads, shared writes, or both. Forbidden patterns are reported on the error flag of every port involved. A shared read returns zero. A shared write leaves the location unchanged. When shared writes are allowed, a two-bit policy field chooses how they are resolved. The choices are: all writers must agree; the highest-numbered writer wins; the lowest-numbered writer wins; or the values are merged. A build parameter selects the merge as a wrapping sum or as the maximum.

Top module: `smem_conflict_mem`

## Requirements
- R1: Each read returns on `rd_data` one clock after the request. It shows the location's content before any write issued in the same step, including a write by another port to that address.
- R2: With `excl_mode[0]`=1 (exclusive read), two or more ports that read one address in a step each get `rd_data`=0 and `port_err`=1 one clock later. Readers of other addresses are unaffected.
- R3: With `excl_mode[0]`=0, any number of ports may read one address in a step. Each gets the same stored value with no read error.
- R4: With `excl_mode[1]`=1 (exclusive write), two or more writes to one address in a step store nothing there. Every colliding writer gets `port_err`=1 one clock later.
- R5: With `excl_mode[1]`=0 and `wr_policy`=2'b00 (agree), colliding writers that all supply one value store that value. If any value differs, nothing is stored and every colliding writer gets `port_err`=1.
- R6: With `excl_mode[1]`=0 and `wr_policy`=2'b01, the value from the highest-numbered colliding writer is stored, with no error.
- R7: With `excl_mode[1]`=0 and `wr_policy`=2'b10, the value from the lowest-numbered colliding writer is stored, with no error.
- R8: With `excl_mode[1]`=0 and `wr_policy`=2'b11, the colliding values are merged and stored, with no error. With `COMBINE_MAX`=0 the merge is their sum modulo 2^`DATA_W`; with `COMBINE_MAX`=1 it is their maximum.
- R9: Writes from different ports to distinct addresses in one step are all stored and raise no error, whatever the mode.
- R10: During and after reset, `rd_data` and `port_err` are zero. After reset, `port_err` rises only for a port that made a request in the previous step.
- R11: A port that does not read in a step gets `rd_data`=0 one clock later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| excl_mode | input | 2 | Bit 0 selects exclusive read; bit 1 selects exclusive write |
| wr_policy | input | 2 | Shared-write policy: 00 agree, 01 highest port, 10 lowest port, 11 merge |
| rd_en | input | N_PORTS | Per-port read request |
| rd_addr | input | N_PORTS*ADDR_W | Per-port read address, port i at bits [i*ADDR_W +: ADDR_W] |
| wr_en | input | N_PORTS | Per-port write request |
| wr_addr | input | N_PORTS*ADDR_W | Per-port write address, port i at bits [i*ADDR_W +: ADDR_W] |
| wr_data | input | N_PORTS*DATA_W | Per-port write data, port i at bits [i*DATA_W +: DATA_W] |
| rd_data | output | N_PORTS*DATA_W | Per-port registered read data |
| port_err | output | N_PORTS | Per-port registered flag for a forbidden or disagreeing access |

## Verification
The hardest outcome to produce from the ports is a collision of three or more writers on one address, combined with a mode that changes the outcome. Example cases are the agree policy with a single differing writer, and the merge policy with a sum that wraps. Uniform random addresses over the full range almost never produce these. The random phase therefore draws addresses from a narrow window of four locations and draws the exclusivity and policy fields anew each step, so multi-port collisions occur in most steps under every policy. Directed steps then pin down overflow of the sum, mixed agree/differ groups, and a read that races a write to the same location.

// File: rtl/smem_pkg.sv
package smem_pkg;

  typedef enum logic [1:0] {
    POL_AGREE  = 2'b00,
    POL_TOP    = 2'b01,
    POL_BOTTOM = 2'b10,
    POL_MERGE  = 2'b11
  } wr_policy_e;

  localparam int EXCL_RD_BIT = 0;
  localparam int EXCL_WR_BIT = 1;

endpackage

// File: rtl/smem_read_check.sv
module smem_read_check #(
  parameter int N  = 4,
  parameter int AW = 4
) (
  input  logic [N-1:0]    rd_en,
  input  logic [N*AW-1:0] rd_addr,
  output logic [N-1:0]    rd_clash
);

  // A port clashes when any other reading port targets its address.
  always_comb begin
    rd_clash = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        if (i != j && rd_en[i] && rd_en[j] &&
            rd_addr[i*AW +: AW] == rd_addr[j*AW +: AW])
          rd_clash[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/smem_write_resolve.sv
module smem_write_resolve
  import smem_pkg::*;
#(
  parameter int N           = 4,
  parameter int AW          = 4,
  parameter int DW          = 16,
  parameter bit COMBINE_MAX = 1'b0
) (
  input  logic [N-1:0]    wr_en,
  input  logic [N*AW-1:0] wr_addr,
  input  logic [N*DW-1:0] wr_data,
  input  logic            excl_wr,
  input  logic [1:0]      wr_policy,
  output logic [N-1:0]    wr_go,
  output logic [N*DW-1:0] wr_val,
  output logic [N-1:0]    wr_err
);

  wr_policy_e pol;
  assign pol = wr_policy_e'(wr_policy);

  for (genvar i = 0; i < N; i++) begin : g_port
    logic [N-1:0]  peer;      // writers sharing this port's address, self included
    logic          has_lower; // a lower-numbered peer exists
    logic          has_other; // any other peer exists
    logic          differs;   // some peer supplies another value
    logic [DW-1:0] own;
    logic [DW-1:0] top_v;
    logic [DW-1:0] merge_v;
    logic [DW-1:0] pick_v;
    logic          blocked;

    always_comb begin
      own       = wr_data[i*DW +: DW];
      peer      = '0;
      has_lower = 1'b0;
      has_other = 1'b0;
      differs   = 1'b0;
      top_v     = own;
      for (int j = 0; j < N; j++) begin
        if (wr_en[i] && wr_en[j] &&
            wr_addr[j*AW +: AW] == wr_addr[i*AW +: AW]) begin
          peer[j] = 1'b1;
          top_v   = wr_data[j*DW +: DW];
          if (wr_data[j*DW +: DW] != own) differs = 1'b1;
          if (j < i) has_lower = 1'b1;
          if (j != i) has_other = 1'b1;
        end
      end
    end

    if (COMBINE_MAX) begin : g_max
      always_comb begin
        merge_v = '0;
        for (int j = 0; j < N; j++) begin
          if (peer[j] && wr_data[j*DW +: DW] > merge_v)
            merge_v = wr_data[j*DW +: DW];
        end
      end
    end else begin : g_sum
      always_comb begin
        merge_v = '0;
        for (int j = 0; j < N; j++) begin
          if (peer[j]) merge_v = merge_v + wr_data[j*DW +: DW];
        end
      end
    end

    always_comb begin
      unique case (pol)
        POL_AGREE:  pick_v = own;
        POL_TOP:    pick_v = top_v;
        POL_BOTTOM: pick_v = own;
        POL_MERGE:  pick_v = merge_v;
        default:    pick_v = own;
      endcase
    end

    assign blocked = has_other && (excl_wr || (pol == POL_AGREE && differs));
    // Only the lowest-numbered writer of a group drives the array.
    assign wr_go[i]            = wr_en[i] && !has_lower && !blocked;
    assign wr_err[i]           = wr_en[i] && blocked;
    assign wr_val[i*DW +: DW]  = pick_v;
  end

endmodule

// File: rtl/smem_array.sv
module smem_array #(
  parameter int N     = 4,
  parameter int AW    = 4,
  parameter int DW    = 16,
  parameter int DEPTH = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [N-1:0]    wr_go,
  input  logic [N*AW-1:0] wr_addr,
  input  logic [N*DW-1:0] wr_val,
  input  logic [N-1:0]    rd_keep,
  input  logic [N*AW-1:0] rd_addr,
  output logic [N*DW-1:0] rd_data
);

  logic [DW-1:0] mem [DEPTH];

  // Write groups have distinct addresses, so loop order never matters.
  always_ff @(posedge clk) begin
    for (int i = 0; i < N; i++) begin
      if (wr_go[i]) mem[wr_addr[i*AW +: AW]] <= wr_val[i*DW +: DW];
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst)             rd_data[i*DW +: DW] <= '0;
      else if (rd_keep[i]) rd_data[i*DW +: DW] <= mem[rd_addr[i*AW +: AW]];
      else                 rd_data[i*DW +: DW] <= '0;
    end
  end

endmodule

// File: rtl/smem_conflict_mem.sv
module smem_conflict_mem
  import smem_pkg::*;
#(
  parameter int N_PORTS     = 4,
  parameter int ADDR_W      = 4,
  parameter int DATA_W      = 16,
  parameter bit COMBINE_MAX = 1'b0
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [1:0]                excl_mode,
  input  logic [1:0]                wr_policy,
  input  logic [N_PORTS-1:0]        rd_en,
  input  logic [N_PORTS*ADDR_W-1:0] rd_addr,
  input  logic [N_PORTS-1:0]        wr_en,
  input  logic [N_PORTS*ADDR_W-1:0] wr_addr,
  input  logic [N_PORTS*DATA_W-1:0] wr_data,
  output logic [N_PORTS*DATA_W-1:0] rd_data,
  output logic [N_PORTS-1:0]        port_err
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [N_PORTS-1:0]        rd_clash;
  logic [N_PORTS-1:0]        rd_bad;
  logic [N_PORTS-1:0]        rd_keep;
  logic [N_PORTS-1:0]        wr_go;
  logic [N_PORTS-1:0]        wr_bad;
  logic [N_PORTS*DATA_W-1:0] wr_val;

  smem_read_check #(.N(N_PORTS), .AW(ADDR_W)) u_rchk (
    .rd_en    (rd_en),
    .rd_addr  (rd_addr),
    .rd_clash (rd_clash)
  );

  assign rd_bad  = rd_clash & {N_PORTS{excl_mode[EXCL_RD_BIT]}};
  assign rd_keep = rd_en & ~rd_bad;

  smem_write_resolve #(
    .N(N_PORTS), .AW(ADDR_W), .DW(DATA_W), .COMBINE_MAX(COMBINE_MAX)
  ) u_wres (
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .excl_wr   (excl_mode[EXCL_WR_BIT]),
    .wr_policy (wr_policy),
    .wr_go     (wr_go),
    .wr_val    (wr_val),
    .wr_err    (wr_bad)
  );

  smem_array #(.N(N_PORTS), .AW(ADDR_W), .DW(DATA_W), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_go   (wr_go),
    .wr_addr (wr_addr),
    .wr_val  (wr_val),
    .rd_keep (rd_keep),
    .rd_addr (rd_addr),
    .rd_data (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) port_err <= '0;
    else     port_err <= rd_bad | wr_bad;
  end

endmodule

// File: rtl/smem_conflict_mem_chk.sv
module smem_conflict_mem_chk #(
  parameter int N_PORTS = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic [1:0]                excl_mode,
  input logic [N_PORTS-1:0]        rd_en,
  input logic [N_PORTS*ADDR_W-1:0] rd_addr,
  input logic [N_PORTS-1:0]        wr_en,
  input logic [N_PORTS*ADDR_W-1:0] wr_addr,
  input logic [N_PORTS*DATA_W-1:0] rd_data,
  input logic [N_PORTS-1:0]        port_err
);

  logic past_ok = 1'b0;
  always_ff @(posedge clk) past_ok <= !rst;

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (port_err == '0 && rd_data == '0)); // R10

  for (genvar i = 0; i < N_PORTS; i++) begin : g_p
    AST_ERR_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
      (past_ok && port_err[i]) |-> $past(rd_en[i] || wr_en[i])); // R10
    AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(!rd_en[i])) |-> rd_data[i*DATA_W +: DATA_W] == '0); // R11
  end

  if (N_PORTS >= 2) begin : g_pair
    AST_EXCL_READ_CLASH: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(excl_mode[0] && rd_en[0] && rd_en[1] &&
                        rd_addr[0 +: ADDR_W] == rd_addr[ADDR_W +: ADDR_W]))
      |-> (port_err[0] && port_err[1] && rd_data[0 +: DATA_W] == '0)); // R2
    AST_SHARED_READ_EQUAL: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(!excl_mode[0] && rd_en[0] && rd_en[1] &&
                        rd_addr[0 +: ADDR_W] == rd_addr[ADDR_W +: ADDR_W]))
      |-> rd_data[0 +: DATA_W] == rd_data[DATA_W +: DATA_W]); // R3
    AST_EXCL_WRITE_CLASH: assert property (@(posedge clk) disable iff (rst)
      (past_ok && $past(excl_mode[1] && wr_en[0] && wr_en[1] &&
                        wr_addr[0 +: ADDR_W] == wr_addr[ADDR_W +: ADDR_W]))
      |-> (port_err[0] && port_err[1])); // R4
  end

endmodule

bind smem_conflict_mem smem_conflict_mem_chk #(
  .N_PORTS(N_PORTS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .excl_mode (excl_mode),
  .rd_en     (rd_en),
  .rd_addr   (rd_addr),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .rd_data   (rd_data),
  .port_err  (port_err)
);

// File: tb/tb_smem_conflict_mem.sv
`timescale 1ns/1ps
module tb_smem_conflict_mem;

  localparam int N     = 4;
  localparam int AW    = 4;
  localparam int DW    = 16;
  localparam int DEPTH = 1 << AW;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      excl_mode = '0;
  logic [1:0]      wr_policy = '0;
  logic [N-1:0]    rd_en = '0;
  logic [N*AW-1:0] rd_addr = '0;
  logic [N-1:0]    wr_en = '0;
  logic [N*AW-1:0] wr_addr = '0;
  logic [N*DW-1:0] wr_data = '0;
  logic [N*DW-1:0] rd_data;
  logic [N-1:0]    port_err;

  always #2 clk = ~clk;

  smem_conflict_mem #(.N_PORTS(N), .ADDR_W(AW), .DATA_W(DW), .COMBINE_MAX(1'b0)) dut (
    .clk(clk), .rst(rst), .excl_mode(excl_mode), .wr_policy(wr_policy),
    .rd_en(rd_en), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_data(rd_data), .port_err(port_err)
  );

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW-1:0] model [DEPTH];
  logic [DW-1:0] exp_rd  [N];
  logic          exp_err [N];
  string         rtag    [N];
  string         wtag    [N];

  // Reference outcome of one step from the requirements.
  task automatic predict();
    logic [DW-1:0] nxt [DEPTH];
    for (int a = 0; a < DEPTH; a++) nxt[a] = model[a];
    for (int i = 0; i < N; i++) begin
      int cnt = 0;
      exp_err[i] = 1'b0;
      wtag[i] = "";
      if (rd_en[i]) begin
        for (int j = 0; j < N; j++)
          if (rd_en[j] && rd_addr[j*AW +: AW] == rd_addr[i*AW +: AW]) cnt++;
        if (excl_mode[0] && cnt > 1) begin
          exp_rd[i] = '0; exp_err[i] = 1'b1; rtag[i] = "R2";
        end else begin
          exp_rd[i] = model[rd_addr[i*AW +: AW]];
          rtag[i] = (cnt > 1) ? "R3" : "R1";
        end
      end else begin
        exp_rd[i] = '0; rtag[i] = "R11";
      end
    end
    for (int i = 0; i < N; i++) begin
      if (wr_en[i]) begin
        int cnt = 0;
        int lo = -1;
        int hi = 0;
        bit same = 1'b1;
        logic [DW-1:0] sum = '0;
        logic [AW-1:0] a = wr_addr[i*AW +: AW];
        for (int j = 0; j < N; j++) begin
          if (wr_en[j] && wr_addr[j*AW +: AW] == a) begin
            cnt++;
            if (lo < 0) lo = j;
            hi = j;
            sum = sum + wr_data[j*DW +: DW];
            if (wr_data[j*DW +: DW] != wr_data[i*DW +: DW]) same = 1'b0;
          end
        end
        if (cnt == 1) begin
          nxt[a] = wr_data[i*DW +: DW]; wtag[i] = "R9";
        end else if (excl_mode[1]) begin
          exp_err[i] = 1'b1; wtag[i] = "R4";
        end else begin
          case (wr_policy)
            2'b00: begin
              wtag[i] = "R5";
              if (same) nxt[a] = wr_data[i*DW +: DW];
              else exp_err[i] = 1'b1;
            end
            2'b01: begin nxt[a] = wr_data[hi*DW +: DW]; wtag[i] = "R6"; end
            2'b10: begin nxt[a] = wr_data[lo*DW +: DW]; wtag[i] = "R7"; end
            default: begin nxt[a] = sum; wtag[i] = "R8"; end
          endcase
        end
      end
    end
    for (int a = 0; a < DEPTH; a++) model[a] = nxt[a];
  endtask

  // Inputs are already set (at a falling edge); apply them and compare.
  task automatic step();
    predict();
    @(posedge clk);
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      n_cmp++;
      if (rd_data[i*DW +: DW] !== exp_rd[i] || port_err[i] !== exp_err[i]) begin
        n_bad++;
        $display("FAIL %s %s port %0d: data %h exp %h, err %b exp %b",
                 rtag[i], wtag[i], i, rd_data[i*DW +: DW], exp_rd[i],
                 port_err[i], exp_err[i]);
      end
    end
  endtask

  task automatic idle();
    rd_en = '0; wr_en = '0; rd_addr = '0; wr_addr = '0; wr_data = '0;
  endtask

  task automatic set_rd(input int p, input int a);
    rd_en[p] = 1'b1; rd_addr[p*AW +: AW] = AW'(a);
  endtask

  task automatic set_wr(input int p, input int a, input logic [DW-1:0] d);
    wr_en[p] = 1'b1; wr_addr[p*AW +: AW] = AW'(a); wr_data[p*DW +: DW] = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL R10 watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    // R10: outputs quiet during reset
    for (int i = 0; i < N; i++) begin
      n_cmp++;
      if (rd_data[i*DW +: DW] !== '0 || port_err[i] !== 1'b0) begin
        n_bad++;
        $display("FAIL R10 port %0d: data %h exp 0, err %b exp 0",
                 i, rd_data[i*DW +: DW], port_err[i]);
      end
    end
    rst = 1'b0;

    // R9: fill every location, four distinct addresses per step
    for (int b = 0; b < DEPTH; b += N) begin
      idle();
      excl_mode = 2'b11;
      for (int p = 0; p < N; p++) set_wr(p, b + p, DW'(16'h1000 + (b + p) * 16'h0111));
      step();
    end

    // R1: read races a write to the same address; old value then new value
    idle(); excl_mode = 2'b00; set_rd(0, 5); set_wr(1, 5, 16'hBEEF); step();
    idle(); set_rd(0, 5); step();

    // R2: exclusive read clash on 3, lone reader on 4
    idle(); excl_mode = 2'b01; set_rd(0, 3); set_rd(1, 3); set_rd(2, 4); step();

    // R3: all four ports read one address concurrently
    idle(); excl_mode = 2'b00; for (int p = 0; p < N; p++) set_rd(p, 7); step();

    // R4: exclusive write clash leaves memory unchanged
    idle(); excl_mode = 2'b10; set_wr(0, 8, 16'h1111); set_wr(2, 8, 16'h2222); step();
    idle(); set_rd(3, 8); step();

    // R5: agreeing writers, then one differing writer
    idle(); excl_mode = 2'b00; wr_policy = 2'b00;
    set_wr(0, 9, 16'h5A5A); set_wr(1, 9, 16'h5A5A); set_wr(3, 9, 16'h5A5A); step();
    idle(); set_wr(0, 9, 16'h0001); set_wr(1, 9, 16'h0001); set_wr(2, 9, 16'h0002); step();
    idle(); set_rd(1, 9); step();

    // R6: highest writer wins
    idle(); wr_policy = 2'b01; set_wr(0, 10, 16'hAAAA); set_wr(2, 10, 16'hCCCC); step();
    idle(); set_rd(0, 10); step();

    // R7: lowest writer wins
    idle(); wr_policy = 2'b10; set_wr(1, 11, 16'h1234); set_wr(3, 11, 16'h4321); step();
    idle(); set_rd(0, 11); step();

    // R8: merged sum wraps past the data width
    idle(); wr_policy = 2'b11;
    set_wr(0, 12, 16'hF000); set_wr(1, 12, 16'h2000); set_wr(2, 12, 16'h0005); step();
    idle(); set_rd(2, 12); step();

    // R11: fully idle step
    idle(); step();

    // Random phase over a narrow address window
    for (int k = 0; k < 3000; k++) begin
      idle();
      excl_mode = 2'($urandom_range(3));
      wr_policy = 2'($urandom_range(3));
      for (int p = 0; p < N; p++) begin
        if ($urandom_range(3) != 0) set_rd(p, $urandom_range(3));
        if ($urandom_range(2) != 0)
          set_wr(p, $urandom_range(3),
                 ($urandom_range(1) != 0) ? DW'(16'h0077) : DW'($urandom));
      end
      step();
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule